// File: doc/BRIEF.md
# Next Fetch-Block Address Predictor

This block tells an instruction fetch unit where the next fetch block starts. It makes one prediction for the whole block and does not predict individual branches. The answer is either "continue sequentially" or "jump to a remembered target". No pre-decode information is needed. Not-taken branches inside a block never stop fetch, so fetch can run past several of them in one block.

The block is indexed with the current fetch-block address. It holds a single table. Each entry in that table keeps three things: a tag, the target address of the last non-sequential exit from that block, and a two-bit saturating direction counter.

The lookup is purely combinational from the address. When the tag hits and the counter's upper bit is set, the stored target is chosen. In every other case the next aligned block address is chosen. A resolve port, driven from later in the pipeline, reports what each fetch block actually did. It trains the matching entry, or allocates a new entry when a taken exit finds no entry.

Top module: `nfp_predictor`

## Requirements
- R1: A synchronous reset invalidates every entry, so every lookup after reset reports no hit and predicts sequential.
- R2: The sequential next address is the lookup address aligned down to a multiple of BLOCK_BYTES, plus BLOCK_BYTES, modulo 2^ADDR_W.
- R3: A lookup whose tag misses predicts sequential (pred_taken=0, pred_next per R2), whatever counter the indexed entry holds.
- R4: A lookup that hits an entry whose counter is 2'b10 or 2'b11 sets pred_taken=1 and drives the stored target on pred_next.
- R5: A lookup that hits an entry whose counter is 2'b00 or 2'b01 sets pred_taken=0 and drives the sequential address on pred_next.
- R6: A taken resolve that misses allocates the entry. It writes the tag and the target and sets the counter to 2'b10, so one later not-taken resolve turns the prediction sequential.
- R7: A not-taken resolve that misses leaves the table unchanged, including an entry of another tag at the same index.
- R8: A resolve that hits adds one to the counter on taken and subtracts one on not-taken, holding at 2'b11 and 2'b00.
- R9: Resolves take effect at the clock edge. A lookup of the same block in the same cycle sees the old state, and the following cycle sees the new state.
- R10: A taken resolve that hits replaces the stored target with the resolved target.
- R11: A taken resolve whose tag differs from the tag held at its index replaces that entry, so the old block then misses.
- R12: The entry index is taken from the address bits just above the block offset, and the tag is taken from all the bits above the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_addr | input | ADDR_W | Current fetch-block address to look up |
| pred_hit | output | 1 | The lookup address matches a valid entry |
| pred_taken | output | 1 | The next block is predicted non-sequential |
| pred_next | output | ADDR_W | Predicted address of the next fetch block |
| upd_valid | input | 1 | A resolve is presented this cycle |
| upd_addr | input | ADDR_W | Address of the fetch block being resolved |
| upd_taken | input | 1 | The block exited non-sequentially |
| upd_target | input | ADDR_W | Address at which fetch actually continued |

## Verification
The assertions assume that upd_addr, upd_taken and upd_target hold known values in any cycle where upd_valid is high, and that reset is asserted for at least one clock edge before the first resolve. The bench changes every input only at the falling clock edge and holds the resolve fields steady for a whole cycle. It releases upd_valid before the next lookup that depends on the result. Lookup addresses are chosen so that some share an index but carry different tags, and the counter state of each entry can be inferred at the ports from the sequence of resolves.

// File: rtl/nfp_pkg.sv
package nfp_pkg;

   typedef logic [1:0] dir_ctr_t;

   localparam dir_ctr_t CTR_WEAK_TAKEN = 2'b10;
   localparam dir_ctr_t CTR_MAX        = 2'b11;
   localparam dir_ctr_t CTR_MIN        = 2'b00;

   // Saturating step of the direction counter
   function automatic dir_ctr_t ctr_step(input dir_ctr_t cur, input logic taken);
      dir_ctr_t nxt;
      if (taken) nxt = (cur == CTR_MAX) ? cur : cur + 2'd1;
      else       nxt = (cur == CTR_MIN) ? cur : cur - 2'd1;
      return nxt;
   endfunction

endpackage

// File: rtl/nfp_seq_addr.sv
module nfp_seq_addr #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] next_addr
);

   generate
      if (OFS_W == 0) begin : g_unit
         assign next_addr = addr + ADDR_W'(1);
      end else begin : g_block
         logic [OFS_W-1:0] unused_ofs;
         assign unused_ofs = addr[OFS_W-1:0];
         assign next_addr  = {addr[ADDR_W-1:OFS_W] + (ADDR_W-OFS_W)'(1), {OFS_W{1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/nfp_table.sv
module nfp_table
   import nfp_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4,
   parameter int TAG_W   = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic              rd_hit,
   output logic              rd_dir,
   output logic [ADDR_W-1:0] rd_tgt,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic              wr_taken,
   input  logic [ADDR_W-1:0] wr_tgt
);

   logic              valid_q [ENTRIES];
   logic [TAG_W-1:0]  tag_q   [ENTRIES];
   logic [ADDR_W-1:0] tgt_q   [ENTRIES];
   dir_ctr_t          ctr_q   [ENTRIES];

   logic wr_hit, do_alloc, do_train;

   assign rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_dir = ctr_q[rd_idx][1];
   assign rd_tgt = tgt_q[rd_idx];

   assign wr_hit   = valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
   assign do_alloc = wr_en && !wr_hit && wr_taken;
   assign do_train = wr_en && wr_hit;

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
         logic sel;
         assign sel = (wr_idx == IDX_W'(e));

         always_ff @(posedge clk) begin
            if (rst)                  valid_q[e] <= 1'b0;
            else if (sel && do_alloc) valid_q[e] <= 1'b1;
         end

         always_ff @(posedge clk) begin
            if (sel && do_alloc) begin
               tag_q[e] <= wr_tag;
               tgt_q[e] <= wr_tgt;
               ctr_q[e] <= CTR_WEAK_TAKEN;
            end else if (sel && do_train) begin
               ctr_q[e] <= ctr_step(ctr_q[e], wr_taken);
               if (wr_taken) tgt_q[e] <= wr_tgt;
            end
         end
      end
   endgenerate

   logic any_valid;
   always_comb begin
      any_valid = 1'b0;
      for (int i = 0; i < ENTRIES; i++) any_valid = any_valid | valid_q[i];
   end

   // R1: nothing is valid on the cycle after reset
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !any_valid);

   // R6: a taken miss leaves a valid, weakly taken entry
   p_alloc_weak_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_taken && !wr_hit) |=>
         (valid_q[$past(wr_idx)] && ctr_q[$past(wr_idx)] == CTR_WEAK_TAKEN));

   // R7: a not-taken miss changes no valid bit and no counter at its index
   p_nt_miss_keep_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_taken && !wr_hit) |=>
         (valid_q[$past(wr_idx)] == $past(valid_q[wr_idx]) &&
          ctr_q[$past(wr_idx)] == $past(ctr_q[wr_idx])));

   // R8: saturation at the top
   p_sat_high_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_hit && wr_taken && ctr_q[wr_idx] == CTR_MAX) |=>
         ctr_q[$past(wr_idx)] == CTR_MAX);

   // R8: saturation at the bottom
   p_sat_low_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_hit && !wr_taken && ctr_q[wr_idx] == CTR_MIN) |=>
         ctr_q[$past(wr_idx)] == CTR_MIN);

endmodule

// File: rtl/nfp_predictor.sv
module nfp_predictor
   import nfp_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int BLOCK_BYTES = 16,
   parameter int ENTRIES     = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              pred_hit,
   output logic              pred_taken,
   output logic [ADDR_W-1:0] pred_next,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic              upd_taken,
   input  logic [ADDR_W-1:0] upd_target
);

   localparam int OFS_W = $clog2(BLOCK_BYTES);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int TAG_W = ADDR_W - OFS_W - IDX_W;

   generate
      if ((1 << OFS_W) != BLOCK_BYTES) begin : g_bad_block
         $error("BLOCK_BYTES must be a power of two");
      end
      if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
         $error("ENTRIES must be a power of two of at least 2");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("ADDR_W too small for block size and entry count");
      end
   endgenerate

   // R12: index just above block offset, tag above index
   logic [IDX_W-1:0] lk_idx, up_idx;
   logic [TAG_W-1:0] lk_tag, up_tag;
   assign lk_idx = lk_addr[OFS_W +: IDX_W];
   assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
   assign up_idx = upd_addr[OFS_W +: IDX_W];
   assign up_tag = upd_addr[ADDR_W-1 -: TAG_W];

   logic unused_upd_ofs;
   assign unused_upd_ofs = ^(upd_addr & ADDR_W'(BLOCK_BYTES - 1));

   logic              tbl_hit, tbl_dir;
   logic [ADDR_W-1:0] tbl_tgt, seq_addr;

   nfp_table #(
      .ADDR_W (ADDR_W),
      .ENTRIES(ENTRIES),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W)
   ) u_table (
      .clk     (clk),
      .rst     (rst),
      .rd_idx  (lk_idx),
      .rd_tag  (lk_tag),
      .rd_hit  (tbl_hit),
      .rd_dir  (tbl_dir),
      .rd_tgt  (tbl_tgt),
      .wr_en   (upd_valid),
      .wr_idx  (up_idx),
      .wr_tag  (up_tag),
      .wr_taken(upd_taken),
      .wr_tgt  (upd_target)
   );

   nfp_seq_addr #(
      .ADDR_W(ADDR_W),
      .OFS_W (OFS_W)
   ) u_seq (
      .addr     (lk_addr),
      .next_addr(seq_addr)
   );

   assign pred_hit   = tbl_hit;
   assign pred_taken = tbl_hit && tbl_dir;
   assign pred_next  = pred_taken ? tbl_tgt : seq_addr;

   // R3: a miss never redirects fetch
   p_miss_seq_r3: assert property (@(posedge clk) disable iff (rst)
      !pred_hit |-> (!pred_taken && pred_next == seq_addr));

   // R2: a sequential prediction lands on a block boundary
   p_seq_aligned_r2: assert property (@(posedge clk) disable iff (rst)
      !pred_taken |-> ((pred_next & ADDR_W'(BLOCK_BYTES - 1)) == '0));

   // R4: a redirect requires a hit and uses the stored target
   p_taken_target_r4: assert property (@(posedge clk) disable iff (rst)
      pred_taken |-> (pred_hit && pred_next == tbl_tgt));

endmodule

// File: tb/tb_nfp_predictor.sv
`timescale 1ns/1ps
module tb_nfp_predictor;

   localparam int AW = 32;
   localparam int BB = 16;
   localparam int EN = 16;

   logic          clk = 1'b0;
   logic          rst;
   logic [AW-1:0] lk_addr;
   logic          pred_hit, pred_taken;
   logic [AW-1:0] pred_next;
   logic          upd_valid;
   logic [AW-1:0] upd_addr;
   logic          upd_taken;
   logic [AW-1:0] upd_target;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   nfp_predictor #(.ADDR_W(AW), .BLOCK_BYTES(BB), .ENTRIES(EN)) dut (
      .clk(clk), .rst(rst), .lk_addr(lk_addr),
      .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_next(pred_next),
      .upd_valid(upd_valid), .upd_addr(upd_addr),
      .upd_taken(upd_taken), .upd_target(upd_target)
   );

   localparam logic [AW-1:0] A  = 32'h0000_1230; // index 3
   localparam logic [AW-1:0] C  = 32'h0000_5230; // index 3, other tag
   localparam logic [AW-1:0] B  = 32'h0000_2250; // index 5
   localparam logic [AW-1:0] D  = 32'h0000_3370; // index 7
   localparam logic [AW-1:0] E  = 32'h0001_3370; // index 7, other tag
   localparam logic [AW-1:0] T1 = 32'h0000_8004;

   function automatic logic [AW-1:0] seq(input logic [AW-1:0] a);
      return (a & ~AW'(BB - 1)) + AW'(BB);
   endfunction

   task automatic expect_pred(input string req, input logic eh, input logic et,
                              input logic [AW-1:0] en);
      checks++;
      if (pred_hit !== eh || pred_taken !== et || pred_next !== en) begin
         errors++;
         $display("FAIL %s: hit/taken/next actual=%0b/%0b/%h expected=%0b/%0b/%h",
                  req, pred_hit, pred_taken, pred_next, eh, et, en);
      end
   endtask

   task automatic look(input string req, input logic [AW-1:0] a, input logic eh,
                       input logic et, input logic [AW-1:0] en);
      @(negedge clk);
      lk_addr = a;
      #1;
      expect_pred(req, eh, et, en);
   endtask

   task automatic resolve(input logic [AW-1:0] a, input logic tk, input logic [AW-1:0] tg);
      @(negedge clk);
      upd_valid  = 1'b1;
      upd_addr   = a;
      upd_taken  = tk;
      upd_target = tg;
      @(negedge clk);
      upd_valid  = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      look("R1", A, 1'b0, 1'b0, seq(A));
      look("R2", 32'h1000_0014, 1'b0, 1'b0, 32'h1000_0020);
      look("R2", 32'hFFFF_FFF8, 1'b0, 1'b0, 32'h0000_0000);
   endtask

   task automatic t_alloc();
      resolve(A, 1'b1, T1);
      look("R6", A, 1'b1, 1'b1, T1);
      look("R4", A + 32'd4, 1'b1, 1'b1, T1);
      look("R12", A ^ 32'h0000_0010, 1'b0, 1'b0, seq(A ^ 32'h0000_0010));
      resolve(A, 1'b0, 32'h0);
      look("R6", A, 1'b1, 1'b0, seq(A));
   endtask

   task automatic t_nt_miss();
      resolve(C, 1'b0, 32'hDEAD_0000);
      look("R7", C, 1'b0, 1'b0, seq(C));
      look("R7", A, 1'b1, 1'b0, seq(A));
      resolve(B, 1'b0, 32'h0000_7770);
      look("R7", B, 1'b0, 1'b0, seq(B));
   endtask

   task automatic t_saturate();
      resolve(A, 1'b0, 32'h0);
      resolve(A, 1'b0, 32'h0);
      resolve(A, 1'b1, T1);
      look("R8", A, 1'b1, 1'b0, seq(A));
      resolve(A, 1'b1, T1);
      look("R4", A, 1'b1, 1'b1, T1);
      resolve(A, 1'b1, T1);
      resolve(A, 1'b1, T1);
      resolve(A, 1'b0, 32'h0);
      look("R8", A, 1'b1, 1'b1, T1);
      resolve(A, 1'b0, 32'h0);
      look("R5", A, 1'b1, 1'b0, seq(A));
   endtask

   task automatic t_retarget();
      resolve(A, 1'b1, 32'h0000_9000);
      look("R10", A, 1'b1, 1'b1, 32'h0000_9000);
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      lk_addr    = D;
      upd_valid  = 1'b1;
      upd_addr   = D;
      upd_taken  = 1'b1;
      upd_target = 32'h0000_4444;
      #1;
      expect_pred("R9", 1'b0, 1'b0, seq(D));
      @(posedge clk);
      #1;
      expect_pred("R9", 1'b1, 1'b1, 32'h0000_4444);
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   task automatic t_conflict();
      resolve(E, 1'b1, 32'h0000_5550);
      look("R11", E, 1'b1, 1'b1, 32'h0000_5550);
      look("R3", D, 1'b0, 1'b0, seq(D));
   endtask

   task automatic t_reset_again();
      do_reset();
      look("R1", A, 1'b0, 1'b0, seq(A));
      look("R1", E, 1'b0, 1'b0, seq(E));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst        = 1'b1;
      lk_addr    = '0;
      upd_valid  = 1'b0;
      upd_addr   = '0;
      upd_taken  = 1'b0;
      upd_target = '0;
      t_reset();
      t_alloc();
      t_nt_miss();
      t_saturate();
      t_retarget();
      t_same_cycle();
      t_conflict();
      t_reset_again();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule